// File: doc/BRIEF.md
# Multicore Snoop Unit Register Interface

This block is the software-visible register window of the snoop control unit in a small multiprocessor cluster. It decodes a 256-byte window at byte-granular offsets and takes reads and writes of 1, 2 or 4 bytes. Three registers hold state or have a value. The first is a one-bit enable. The second is a read-only configuration word derived from the core-count parameter. The third is a 32-bit per-core power status word that can be read and written a byte lane at a time.

The filter address pair, the access-control pair and the invalidate-all offset are decoded but hold nothing. They read as zero and drop writes, and so does every other offset. The block does no coherency work. The bus side is a single-cycle register port: a write takes effect on the clock edge that samples its strobe, and read data appears one cycle after the read strobe, marked by a valid flag.

Top module: `snoop_regs`

## Requirements
- R1: While reset is low, and after it is released, the enable register reads as zero. Reset also clears the read-valid flag.
- R2: A write to offset 0x00 with a legal size stores only bit 0 of the write data. A read of 0x00 returns that bit in bit 0 and zeros in bits 31:1.
- R3: Offset 0x04 reads as ((2^N - 1) << 4) | (N - 1), where N is the core-count parameter (default 1, which gives 0x10). Writes to 0x04 change nothing.
- R4: A read at offset 0x08+k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with zeros filled in at the top.
- R5: A write at 0x08+k replaces the bytes of the power status word at positions k to k+size-1 with write-data bytes 0 upward. All other bytes keep their values.
- R6: A write whose byte span runs past bit 31 of the power status word updates only the bytes that exist. The write data beyond that point is dropped.
- R7: The size input carries the access width in bytes. Only 1, 2 and 4 are legal. A write with any other size value changes neither the enable nor the power status register.
- R8: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset apart from 0x00, 0x04 and 0x08 to 0x0B read as zero. Writes to them change no register.
- R9: Reset leaves the power status word unchanged.
- R10: The read data and its valid flag appear in the cycle after the read strobe. Valid is low in any cycle that follows a cycle with no read. If a read and a write arrive in the same cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | 8 | Byte offset within the window |
| bus_size | input | 3 | Access width in bytes (1, 2 or 4 legal) |
| bus_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata holds read data |

## Verification
A read and a write can be accepted in the same cycle, and they can target the same register. The design must then return the value from before the write, with the update visible only to later reads. The bench provokes this by driving both strobes in one cycle, both on the enable register and on the power status word at a byte offset. A scoreboard entry built from the reference model's pre-write state judges the read. A follow-up read, predicted from the post-write model, judges the update.

// File: rtl/snp_pkg.sv
package snp_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;
    localparam int SIZE_W = 3;
    localparam int LANES  = DATA_W / 8;

    localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h00;
    localparam logic [OFF_W-1:0] OFF_CONFIG = 8'h04;
    localparam logic [OFF_W-1:0] OFF_PWR    = 8'h08;

    typedef struct packed {
        logic              enable;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic is_pwr_off(input logic [OFF_W-1:0] off);
        return off[OFF_W-1:2] == OFF_PWR[OFF_W-1:2];
    endfunction

endpackage

// File: rtl/snp_cfg_word.sv
module snp_cfg_word
    import snp_pkg::*;
#(
    parameter int NCORES = 1
) (
    output logic [DATA_W-1:0] cfg_word
);
    localparam int CNT_W = 2;

    initial begin
        if (NCORES < 1 || NCORES > 4) $error("NCORES must be 1..4");
    end

    always_comb begin
        cfg_word = '0;
        cfg_word[CNT_W-1:0] = CNT_W'(NCORES - 1);
        for (int c = 0; c < NCORES; c++) begin
            cfg_word[4 + c] = 1'b1;
        end
    end

endmodule

// File: rtl/snp_pwr_merge.sv
module snp_pwr_merge
    import snp_pkg::*;
(
    input  logic              wr_en,
    input  logic [1:0]        lane_base,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt
);
    logic [DATA_W-1:0] wdata_sh;

    assign wdata_sh = wdata << {lane_base, 3'b000};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic hit;
        always_comb begin
            hit = wr_en
                  && (j >= int'(lane_base))
                  && ((j - int'(lane_base)) < int'(size));
        end
        assign nxt[8*j +: 8] = hit ? wdata_sh[8*j +: 8] : cur[8*j +: 8];
    end

endmodule

// File: rtl/snp_rd_mux.sv
module snp_rd_mux
    import snp_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic              enable,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] pwr,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        if (off == OFF_ENABLE) begin
            data[0] = enable;
        end else if (off == OFF_CONFIG) begin
            data = cfg_word;
        end else if (is_pwr_off(off)) begin
            data = pwr >> {off[1:0], 3'b000};
        end
    end

endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
    import snp_pkg::*;
#(
    parameter int NCORES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    port_state_t       st_d, st_q;
    logic [DATA_W-1:0] pwr_d, pwr_q;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] rd_val;
    logic              wr_ok;

    assign wr_ok = bus_wr && size_legal(bus_size);

    snp_cfg_word #(.NCORES(NCORES)) cfg_i (
        .cfg_word (cfg_word)
    );

    snp_pwr_merge pwr_i (
        .wr_en     (wr_ok && is_pwr_off(bus_off)),
        .lane_base (bus_off[1:0]),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .cur       (pwr_q),
        .nxt       (pwr_d)
    );

    snp_rd_mux mux_i (
        .off      (bus_off),
        .enable   (st_q.enable),
        .cfg_word (cfg_word),
        .pwr      (pwr_q),
        .data     (rd_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        if (bus_rd) begin
            st_d.rdata = rd_val;
        end
        if (wr_ok && bus_off == OFF_ENABLE) begin
            st_d.enable = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // power status word deliberately outside reset
    always_ff @(posedge clk) begin
        pwr_q <= pwr_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;

    // R1
    rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.enable == 1'b0 && !bus_rvalid));

    // R2
    enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_off == OFF_ENABLE && size_legal(bus_size))
        |=> st_q.enable == $past(bus_wdata[0]));

    // R3
    cfg_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_off == OFF_CONFIG) |=> (bus_rvalid && bus_rdata == cfg_word));

    // R7
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !size_legal(bus_size)) |=> $stable(st_q.enable));

    // R8
    dead_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_off != OFF_ENABLE && bus_off != OFF_CONFIG && !is_pwr_off(bus_off))
        |=> bus_rdata == '0);

    // R10
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R10
    no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !$isunknown(bus_rd)) |=> !bus_rvalid);

endmodule

// File: tb/snoop_regs_tb.sv
module snoop_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_off = '0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    typedef struct {
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        m_en = 1'b0;
    logic [31:0] m_pwr = '0;
    localparam logic [31:0] CFG_EXP = 32'h0000_0010; // N=1

    always #5 clk = ~clk;

    snoop_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    function automatic logic [31:0] model_read(input logic [7:0] off);
        if (off == 8'h00) return {31'b0, m_en};
        if (off == 8'h04) return CFG_EXP;
        if (off >= 8'h08 && off <= 8'h0B) return m_pwr >> (8 * (off - 8'h08));
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        logic [63:0] msk;
        logic [63:0] dat;
        if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) return;
        if (off == 8'h00) m_en = d[0];
        if (off >= 8'h08 && off <= 8'h0B) begin
            msk = (sz == 3'd1) ? 64'hFF : (sz == 3'd2) ? 64'hFFFF : 64'hFFFF_FFFF;
            dat = {32'b0, d} & msk;
            msk = msk << (8 * (off - 8'h08));
            dat = dat << (8 * (off - 8'h08));
            m_pwr = (m_pwr & ~msk[31:0]) | dat[31:0];
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic [7:0] off,
                         input logic [2:0] sz, input logic [31:0] d, input string req);
        exp_t e;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_off = off; bus_size = sz; bus_wdata = d;
        if (rd) begin
            e.val = model_read(off);
            e.req = req;
            sb.push_back(e);
        end
        if (wr) model_write(off, sz, d);
    endtask

    task automatic rd(input logic [7:0] off, input string req);
        drive(1'b1, 1'b0, off, 3'd4, 32'h0, req);
    endtask

    task automatic wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        drive(1'b0, 1'b1, off, sz, d, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_rd = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic check(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare every read response against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_rvalid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected valid", bus_rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(bus_rdata === e.val, e.req, bus_rdata, e.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // power status has no reset: give it a known value first
        repeat (2) @(negedge clk);
        wr(8'h08, 3'd4, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        check(bus_rvalid === 1'b0, "R1 valid after reset", {31'b0, bus_rvalid}, 32'h0);
        rd(8'h00, "R1 enable after reset");
        rd(8'h04, "R3 config word");
        // R2 enable register
        wr(8'h00, 3'd4, 32'hFFFF_FFFF);
        rd(8'h00, "R2 enable set, upper bits zero");
        wr(8'h00, 3'd1, 32'h0000_00FE);
        rd(8'h00, "R2 enable cleared by bit0");
        // R3 read-only
        wr(8'h04, 3'd4, 32'hDEAD_BEEF);
        rd(8'h04, "R3 config ignores write");
        // R4 byte-offset reads
        wr(8'h08, 3'd4, 32'h1122_3344);
        rd(8'h08, "R4 offset 0");
        rd(8'h09, "R4 offset 1");
        rd(8'h0A, "R4 offset 2");
        rd(8'h0B, "R4 offset 3");
        // R5 partial writes
        wr(8'h0A, 3'd1, 32'h0000_00AB);
        rd(8'h08, "R5 byte write at lane 2");
        wr(8'h09, 3'd2, 32'hFFFF_CDEF);
        rd(8'h08, "R5 halfword write at lane 1");
        // R6 overflow past bit 31
        wr(8'h0B, 3'd4, 32'hA5A5_A5A5);
        rd(8'h08, "R6 word write at lane 3");
        wr(8'h0B, 3'd2, 32'h0000_7766);
        rd(8'h08, "R6 halfword write at lane 3");
        wr(8'h0A, 3'd4, 32'h1357_9BDF);
        rd(8'h08, "R6 word write at lane 2");
        // R7 illegal sizes
        wr(8'h08, 3'd3, 32'h0);
        wr(8'h08, 3'd0, 32'h0);
        wr(8'h00, 3'd7, 32'h1);
        rd(8'h08, "R7 power word after illegal sizes");
        rd(8'h00, "R7 enable after illegal size");
        // R8 dead offsets
        wr(8'h0C, 3'd4, 32'hFFFF_FFFF);
        wr(8'h40, 3'd4, 32'hFFFF_FFFF);
        wr(8'h44, 3'd4, 32'hFFFF_FFFF);
        wr(8'h50, 3'd4, 32'hFFFF_FFFF);
        wr(8'h54, 3'd4, 32'hFFFF_FFFF);
        wr(8'h0C, 3'd1, 32'h0000_0001);
        rd(8'h0C, "R8 invalidate reads zero");
        rd(8'h40, "R8 filter start reads zero");
        rd(8'h44, "R8 filter end reads zero");
        rd(8'h50, "R8 access ctrl reads zero");
        rd(8'h54, "R8 nonsecure ctrl reads zero");
        rd(8'hFC, "R8 top offset reads zero");
        rd(8'h10, "R8 gap offset reads zero");
        rd(8'h08, "R8 power word untouched");
        rd(8'h00, "R8 enable untouched");
        // R10 same-cycle read and write
        drive(1'b1, 1'b1, 8'h00, 3'd1, 32'h1, "R10 enable read before write");
        rd(8'h00, "R10 enable after write");
        drive(1'b1, 1'b1, 8'h09, 3'd1, 32'h0000_0042, "R10 power read before write");
        rd(8'h08, "R10 power after write");
        idle(2);
        // R9 / R1 reset behaviour
        wr(8'h08, 3'd4, 32'hCAFE_F00D);
        wr(8'h00, 3'd1, 32'h1);
        idle(1);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        m_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, "R1 enable cleared by reset");
        rd(8'h08, "R9 power word kept through reset");
        idle(3);
        check(sb.size() == 0, "R10 all reads answered", sb.size(), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule